// File: doc/BRIEF.md
# Paged address translation unit

This block sits between a processor's address-generating logic and the memory system. It turns 32-bit virtual addresses into physical addresses using 1 KB pages. The low 10 bits pass through unchanged. The upper 22 bits form the virtual page number. That number is looked up in a small fully associative cache of recent translations. When the lookup misses, the block fetches the matching 4-byte table entry from a page table in physical memory. Before it answers, it checks the entry's valid flag and its access permissions against the type of access.

A configuration write loads a new table base address. This switches the unit to another process's mappings and empties the translation cache at once. The requester receives one response for each accepted request. The response carries the physical address and a 2-bit status; a fault response reports a page fault or a protection fault instead of an address. Only one table fetch is in flight at any time, and the unit accepts no new request until the previous response has been taken.

Top module: `xlat_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_rd_valid` are 0.
- R2: A request whose page is held in the translation cache produces `rsp_valid` in the cycle after acceptance and issues no memory read. The result is `rsp_paddr = {ppn, vaddr[9:0]}`.
- R3: A request that misses issues exactly one memory read at `base + vaddr[31:10]*4`, where `base` is the table base register value at acceptance. The response follows once the read data arrives.
- R4: A table entry has valid at bit 31, execute at bit 30, write at bit 29, read at bit 28 and the physical page number at bits 21:0. The status codes are 00 ok, 01 page fault and 10 protection fault. An entry with bit 31 clear gives a page fault, and every fault response carries `rsp_paddr = 0`.
- R5: `req_kind` encodes 0 as read, 1 as write and 2 as execute. A valid entry whose permission bit for that kind is clear gives a protection fault, and kind 3 always gives a protection fault. The check also applies on a cache hit, against the permissions stored with the entry.
- R6: A translation that faulted is not installed in the cache, so repeating the same access walks the table again.
- R7: The cache holds 8 translations. When it is full, a new translation replaces the least recently used entry, and both hits and installs count as uses.
- R8: A base register write invalidates every cached translation. Later misses read entries relative to the new base.
- R9: If the base register is written while a walk is in flight, that walk's response is still returned, but its translation is not installed.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds its value and `req_ready` stays 0. While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, `mem_rd_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table base register write strobe |
| cfg_base | input | 32 | New table base address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access type: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| mem_rd_valid | output | 1 | Table entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Physical address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read from memory |

## Verification
The bench repeats an access that faulted. A design that cached faulting entries would answer the repeat without a table read, and the walk counter catches that. It fills all eight slots, touches the oldest entry, and then forces evictions. A wrong replacement choice shows up as an extra walk for a page that should have stayed, or a missing walk for one that should have gone. It writes the base register in the middle of a slow walk. A design that installed that result would later hit on a mapping from the old table, giving the wrong physical page. It also holds off `rsp_ready`. A design that dropped or changed the response, or accepted a new request meanwhile, fails the stability checks.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int PTE_VALID_BIT = 31;
   localparam int PTE_EXEC_BIT  = 30;
   localparam int PTE_WRITE_BIT = 29;
   localparam int PTE_READ_BIT  = 28;

   typedef enum logic [1:0] {
      ST_OK    = 2'b00,
      ST_PGF   = 2'b01,
      ST_PROT  = 2'b10
   } xlat_status_e;

   typedef enum logic [1:0] {
      K_READ  = 2'd0,
      K_WRITE = 2'd1,
      K_EXEC  = 2'd2,
      K_RSVD  = 2'd3
   } xlat_kind_e;

   typedef enum logic [1:0] {
      WS_IDLE,
      WS_REQ,
      WS_WAIT
   } walk_state_e;
endpackage

// File: rtl/xlat_perm.sv
module xlat_perm (
   input  logic [2:0] perm,
   input  logic [1:0] kind,
   output logic       ok
);
   import xlat_pkg::*;

   always_comb begin
      case (xlat_kind_e'(kind))
         K_READ:  ok = perm[0];
         K_WRITE: ok = perm[1];
         K_EXEC:  ok = perm[2];
         default: ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 22,
   parameter int PPN_W   = 22,
   parameter int REPL    = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   output logic [2:0]       lk_perm,
   input  logic             touch,
   input  logic             ins_en,
   input  logic [VPN_W-1:0] ins_vpn,
   input  logic [PPN_W-1:0] ins_ppn,
   input  logic [2:0]       ins_perm
);
   localparam int IW = $clog2(ENTRIES);

   logic [ENTRIES-1:0] vld_q;
   logic [VPN_W-1:0]   tag_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   logic [2:0]         perm_q [ENTRIES];
   logic [IW-1:0]      hidx;
   logic [IW-1:0]      repl_idx;
   logic [IW-1:0]      victim;
   logic               upd_en;
   logic [IW-1:0]      upd_idx;

   always_comb begin
      lk_hit = 1'b0;
      hidx   = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (vld_q[i] && tag_q[i] == lk_vpn) begin
            lk_hit = 1'b1;
            hidx   = IW'(i);
         end
      end
   end

   assign lk_ppn  = ppn_q[hidx];
   assign lk_perm = perm_q[hidx];

   always_comb begin
      victim = repl_idx;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!vld_q[i]) victim = IW'(i);
      end
   end

   assign upd_en  = !flush && ((touch && lk_hit) || ins_en);
   assign upd_idx = ins_en ? victim : hidx;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         vld_q <= '0;
      end else if (ins_en) begin
         vld_q[victim] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (ins_en && !flush) begin
         tag_q[victim]  <= ins_vpn;
         ppn_q[victim]  <= ins_ppn;
         perm_q[victim] <= ins_perm;
      end
   end

   generate
      if (REPL == 0) begin : g_lru
         logic [IW-1:0] age_q [ENTRIES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < ENTRIES; i++) age_q[i] <= IW'(i);
            end else if (upd_en) begin
               for (int i = 0; i < ENTRIES; i++) begin
                  if (IW'(i) == upd_idx)          age_q[i] <= '0;
                  else if (age_q[i] < age_q[upd_idx]) age_q[i] <= age_q[i] + 1'b1;
               end
            end
         end
         always_comb begin
            repl_idx = '0;
            for (int i = 0; i < ENTRIES; i++) begin
               if (age_q[i] == IW'(ENTRIES - 1)) repl_idx = IW'(i);
            end
         end
      end else begin : g_rr
         logic [IW-1:0] ptr_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                           ptr_q <= '0;
            else if (upd_en && upd_idx == ptr_q)  ptr_q <= ptr_q + 1'b1;
         end
         assign repl_idx = ptr_q;
      end
   endgenerate
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit #(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 10,
   parameter int ENTRIES   = 8,
   parameter int REPL      = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic [1:0]        req_kind,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic [1:0]        rsp_status,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data
);
   import xlat_pkg::*;

   localparam int VPN_W = ADDR_W - PAGE_BITS;
   localparam int PPN_W = VPN_W;

   generate
      if (ADDR_W != 32)                              begin : g_err_aw  $error("ADDR_W must be 32"); end
      if (PAGE_BITS < 10 || PAGE_BITS > 20)          begin : g_err_pg  $error("PAGE_BITS out of range"); end
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_err_en $error("ENTRIES must be a power of two"); end
      if (REPL != 0 && REPL != 1)                    begin : g_err_rp  $error("REPL must be 0 or 1"); end
   endgenerate

   walk_state_e       state_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] waddr_q;
   logic [VPN_W-1:0]  wvpn_q;
   logic [PAGE_BITS-1:0] woff_q;
   logic [1:0]        wkind_q;
   logic              stale_q;
   logic              rsp_valid_q;
   logic [ADDR_W-1:0] rsp_paddr_q;
   logic [1:0]        rsp_status_q;

   logic              accept;
   logic              lk_hit;
   logic [PPN_W-1:0]  lk_ppn;
   logic [2:0]        lk_perm;
   logic              hit_ok;
   logic              walk_ok;
   logic              walk_done;
   logic              pte_v;
   logic [2:0]        pte_perm;
   logic [PPN_W-1:0]  pte_ppn;
   logic              ins_en;
   logic              unused_pte_bits;

   assign req_ready = (state_q == WS_IDLE) && !rsp_valid_q;
   assign accept    = req_valid && req_ready;

   assign pte_v     = mem_rsp_data[PTE_VALID_BIT];
   assign pte_perm  = {mem_rsp_data[PTE_EXEC_BIT], mem_rsp_data[PTE_WRITE_BIT], mem_rsp_data[PTE_READ_BIT]};
   assign pte_ppn   = mem_rsp_data[PPN_W-1:0];
   assign unused_pte_bits = ^mem_rsp_data[27:PPN_W];

   assign walk_done = (state_q == WS_WAIT) && mem_rsp_valid;
   assign ins_en    = walk_done && pte_v && walk_ok && !stale_q && !cfg_we;

   xlat_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .REPL(REPL)) tlb_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (cfg_we),
      .lk_vpn   (req_vaddr[ADDR_W-1:PAGE_BITS]),
      .lk_hit   (lk_hit),
      .lk_ppn   (lk_ppn),
      .lk_perm  (lk_perm),
      .touch    (accept),
      .ins_en   (ins_en),
      .ins_vpn  (wvpn_q),
      .ins_ppn  (pte_ppn),
      .ins_perm (pte_perm)
   );

   xlat_perm hit_chk_i  (.perm(lk_perm),  .kind(req_kind), .ok(hit_ok));
   xlat_perm walk_chk_i (.perm(pte_perm), .kind(wkind_q),  .ok(walk_ok));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (cfg_we) begin
         base_q <= cfg_base;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= WS_IDLE;
         stale_q      <= 1'b0;
         rsp_valid_q  <= 1'b0;
         rsp_paddr_q  <= '0;
         rsp_status_q <= ST_OK;
         waddr_q      <= '0;
         wvpn_q       <= '0;
         woff_q       <= '0;
         wkind_q      <= '0;
      end else begin
         if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
         if (cfg_we) stale_q <= 1'b1;
         case (state_q)
            WS_IDLE: begin
               if (accept && lk_hit) begin
                  rsp_valid_q  <= 1'b1;
                  rsp_status_q <= hit_ok ? ST_OK : ST_PROT;
                  rsp_paddr_q  <= hit_ok ? {lk_ppn, req_vaddr[PAGE_BITS-1:0]} : '0;
               end else if (accept) begin
                  state_q <= WS_REQ;
                  stale_q <= cfg_we;
                  waddr_q <= base_q + ADDR_W'({req_vaddr[ADDR_W-1:PAGE_BITS], 2'b00});
                  wvpn_q  <= req_vaddr[ADDR_W-1:PAGE_BITS];
                  woff_q  <= req_vaddr[PAGE_BITS-1:0];
                  wkind_q <= req_kind;
               end
            end
            WS_REQ: begin
               if (mem_rd_ready) state_q <= WS_WAIT;
            end
            WS_WAIT: begin
               if (walk_done) begin
                  state_q     <= WS_IDLE;
                  rsp_valid_q <= 1'b1;
                  if (!pte_v) begin
                     rsp_status_q <= ST_PGF;
                     rsp_paddr_q  <= '0;
                  end else if (!walk_ok) begin
                     rsp_status_q <= ST_PROT;
                     rsp_paddr_q  <= '0;
                  end else begin
                     rsp_status_q <= ST_OK;
                     rsp_paddr_q  <= {pte_ppn, woff_q};
                  end
               end
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   assign rsp_valid    = rsp_valid_q;
   assign rsp_paddr    = rsp_paddr_q;
   assign rsp_status   = rsp_status_q;
   assign mem_rd_valid = (state_q == WS_REQ);
   assign mem_rd_addr  = waddr_q;
endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [ADDR_W-1:0] rsp_paddr,
   input logic [1:0]        rsp_status,
   input logic              mem_rd_valid,
   input logic              mem_rd_ready,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              lk_hit
);
   a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_status));

   a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

   a_r10_busy_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid || rsp_valid) |-> !req_ready);

   a_r4_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_status != 2'b11);

   a_r4_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status != 2'b00 |-> rsp_paddr == '0);

   a_r2_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && lk_hit |=> rsp_valid && !mem_rd_valid);
endmodule

bind xlat_unit xlat_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .rsp_valid    (rsp_valid),
   .rsp_ready    (rsp_ready),
   .rsp_paddr    (rsp_paddr),
   .rsp_status   (rsp_status),
   .mem_rd_valid (mem_rd_valid),
   .mem_rd_ready (mem_rd_ready),
   .mem_rd_addr  (mem_rd_addr),
   .lk_hit       (lk_hit)
);

// File: tb/xlat_unit_tb_top.sv
`timescale 1ns/1ps
module xlat_unit_tb_top;
   localparam logic [31:0] BASE_A = 32'h0001_0000;
   localparam logic [31:0] BASE_B = 32'h0100_0000;
   localparam int NV = 23;
   // {vaddr, kind, expect_walk}
   localparam logic [34:0] VEC [NV] = '{
      {22'h001, 10'h123, 2'd0, 1'b1},
      {22'h001, 10'h3FF, 2'd0, 1'b0},
      {22'h001, 10'h000, 2'd1, 1'b0},
      {22'h00F, 10'h010, 2'd0, 1'b1},
      {22'h00F, 10'h010, 2'd0, 1'b1},
      {22'h003, 10'h2A0, 2'd1, 1'b1},
      {22'h004, 10'h044, 2'd0, 1'b1},
      {22'h004, 10'h044, 2'd0, 1'b1},
      {22'h005, 10'h155, 2'd2, 1'b1},
      {22'h001, 10'h001, 2'd3, 1'b0},
      {22'h008, 10'h008, 2'd0, 1'b1},
      {22'h009, 10'h009, 2'd0, 1'b1},
      {22'h00A, 10'h00A, 2'd0, 1'b1},
      {22'h00B, 10'h00B, 2'd0, 1'b1},
      {22'h010, 10'h010, 2'd0, 1'b1},
      {22'h001, 10'h200, 2'd0, 1'b0},
      {22'h011, 10'h011, 2'd0, 1'b1},
      {22'h003, 10'h333, 2'd1, 1'b1},
      {22'h001, 10'h111, 2'd0, 1'b0},
      {22'h008, 10'h080, 2'd0, 1'b0},
      {22'h005, 10'h005, 2'd2, 1'b1},
      {22'h00A, 10'h0AA, 2'd0, 1'b0},
      {22'h009, 10'h099, 2'd0, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_base = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_status;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b1;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;

   int tests = 0;
   int fails = 0;
   int walks = 0;
   int mem_lat = 1;
   logic [31:0] last_addr = '0;
   logic [31:0] cur_base = BASE_A;

   always #10 clk = ~clk;

   xlat_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_status(rsp_status),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   function automatic logic [21:0] ppn_of(input logic [31:0] b, input logic [21:0] vpn);
      return vpn ^ ((b == BASE_B) ? 22'h0AAAA : 22'h15555);
   endfunction

   function automatic logic [31:0] pte_at(input logic [31:0] addr);
      logic [31:0] b;
      logic [21:0] vpn;
      b   = (addr >= BASE_B) ? BASE_B : BASE_A;
      vpn = 22'((addr - b) >> 2);
      return {vpn[3:0] != 4'hF, vpn[0], vpn[1], !vpn[2], 6'b0, ppn_of(b, vpn)};
   endfunction

   function automatic void expect_of(input logic [31:0] b, input logic [31:0] va, input logic [1:0] k,
                                     output logic [1:0] st, output logic [31:0] pa);
      logic [21:0] vpn;
      logic ok;
      vpn = va[31:10];
      case (k)
         2'd0: ok = !vpn[2];
         2'd1: ok = vpn[1];
         2'd2: ok = vpn[0];
         default: ok = 1'b0;
      endcase
      if (vpn[3:0] == 4'hF) begin st = 2'b01; pa = '0; end
      else if (!ok)         begin st = 2'b10; pa = '0; end
      else                  begin st = 2'b00; pa = {ppn_of(b, vpn), va[9:0]}; end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rsp_valid <= 1'b0;
         mem_rsp_data  <= '0;
      end else begin : mem_model
         logic pend;
         int   cnt;
         mem_rsp_valid <= 1'b0;
         if (pend) begin
            if (cnt == 0) begin
               mem_rsp_valid <= 1'b1;
               mem_rsp_data  <= pte_at(last_addr);
               pend = 1'b0;
            end else cnt = cnt - 1;
         end else if (mem_rd_valid && mem_rd_ready) begin
            pend = 1'b1;
            cnt  = mem_lat - 1;
            last_addr <= mem_rd_addr;
            walks <= walks + 1;
         end
      end
   end

   task automatic check(input logic cond, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!cond) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_req(input logic [31:0] va, input logic [1:0] k,
                         output logic [1:0] st, output logic [31:0] pa, output int lat, output int nw);
      int w0;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_kind = k;
      while (!req_ready) @(negedge clk);
      w0 = walks;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 60) begin @(negedge clk); lat++; end
      st = rsp_status; pa = rsp_paddr; nw = walks - w0;
      @(posedge clk);
   endtask

   task automatic write_base(input logic [31:0] b);
      @(negedge clk);
      cfg_we = 1'b1; cfg_base = b;
      @(negedge clk);
      cfg_we = 1'b0;
      cur_base = b;
   endtask

   task automatic run_one(input logic [31:0] va, input logic [1:0] k, input int exp_walk, input string tag);
      logic [1:0] st, est;
      logic [31:0] pa, epa;
      int lat, nw;
      do_req(va, k, st, pa, lat, nw);
      expect_of(cur_base, va, k, est, epa);
      check(st == est, {tag, " status"}, 32'(st), 32'(est));
      check(pa == epa, {tag, " paddr"}, pa, epa);
      check(nw == exp_walk, {tag, " walk count"}, 32'(nw), 32'(exp_walk));
      if (exp_walk == 1)
         check(last_addr == cur_base + {8'h0, va[31:10], 2'b00}, "R3 table read address", last_addr,
               cur_base + {8'h0, va[31:10], 2'b00});
      if (exp_walk == 0)
         check(lat == 1, "R2 hit latency", 32'(lat), 32'd1);
   endtask

   task automatic finish_run;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
      check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
      check(mem_rd_valid == 1'b0, "R1 mem_rd_valid", 32'(mem_rd_valid), 32'd0);

      write_base(BASE_A);
      // R2 R3 R4 R5 R6 R7 vector walk
      for (int i = 0; i < NV; i++) begin
         run_one(VEC[i][34:3], VEC[i][2:1], int'(VEC[i][0]), $sformatf("R2-R7 vec %0d", i));
      end

      // R8: base write flushes; new base used
      write_base(BASE_B);
      run_one({22'h001, 10'h0C3}, 2'd0, 1, "R8 flush and new base");
      run_one({22'h001, 10'h0C4}, 2'd0, 0, "R8 reinstall hit");

      // R10: response held under backpressure
      begin
         logic [31:0] pa0;
         @(negedge clk);
         rsp_ready = 1'b0;
         req_valid = 1'b1; req_vaddr = {22'h001, 10'h055}; req_kind = 2'd0;
         while (!req_ready) @(negedge clk);
         @(posedge clk);
         @(negedge clk);
         req_valid = 1'b0;
         pa0 = rsp_paddr;
         check(rsp_valid == 1'b1, "R10 response present", 32'(rsp_valid), 32'd1);
         check(pa0 == {ppn_of(BASE_B, 22'h001), 10'h055}, "R10 paddr", pa0, {ppn_of(BASE_B, 22'h001), 10'h055});
         for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check(rsp_valid && rsp_paddr == pa0, "R10 response held", rsp_paddr, pa0);
            check(req_ready == 1'b0, "R10 no accept while pending", 32'(req_ready), 32'd0);
         end
         rsp_ready = 1'b1;
         @(negedge clk);
         check(rsp_valid == 1'b0, "R10 response taken", 32'(rsp_valid), 32'd0);
      end

      // R9: base write while a walk is in flight
      mem_lat = 5;
      begin
         logic [1:0] st;
         logic [31:0] pa;
         int lat, nw;
         fork
            do_req({22'h002, 10'h222}, 2'd0, st, pa, lat, nw);
            begin
               repeat (3) @(negedge clk);
               cfg_we = 1'b1; cfg_base = BASE_A;
               @(negedge clk);
               cfg_we = 1'b0;
            end
         join
         check(st == 2'b00, "R9 in-flight status", 32'(st), 32'd0);
         check(pa == {ppn_of(BASE_B, 22'h002), 10'h222}, "R9 in-flight uses old table", pa,
               {ppn_of(BASE_B, 22'h002), 10'h222});
         check(nw == 1, "R9 in-flight walk", 32'(nw), 32'd1);
      end
      cur_base = BASE_A;
      mem_lat = 1;
      run_one({22'h002, 10'h022}, 2'd0, 1, "R9 not installed");
      run_one({22'h002, 10'h023}, 2'd0, 0, "R9 later install hits");

      finish_run();
   end
endmodule